// File: doc/BRIEF.md
# Integer ALU with Zero and Overflow Flags

This block is the purely combinational arithmetic and logic unit of a 32-bit integer datapath. It takes two register operands and a four-bit operation code, and it returns a 32-bit result together with a zero flag and a signed-overflow flag. The second operand can instead come from a 16-bit immediate field. A control input selects whether that immediate is widened with its sign bit or with zeros.

Subtraction reuses the adder: the second operand is inverted and the carry-in is forced to one. The carry chain provides the carry into the top bit and the carry out of it. Overflow is the XOR of those two carries. It is reported only when the operation is an add or subtract and the caller marks the operation as signed, so the unsigned add and subtract forms leave the flag low.

The two comparison operations place a single result bit in bit 0 and clear all other bits. The signed form takes the raw sign of A−B and does not correct it when the subtraction overflows. The unsigned form reports a borrow. The zero flag feeds equal and not-equal branch decisions.

Top module: `intalu`

## Requirements
- R1: Code 0000 gives A AND B, code 0001 gives A OR B, code 1100 gives NOT(A OR B), and code 1101 gives A XOR B. The logic codes never raise the overflow flag.
- R2: Code 0010 gives (A + B) modulo 2^32.
- R3: Code 0110 gives (A − B) modulo 2^32, formed as A + ~B + 1.
- R4: When `arith_signed` is 1 and the code is 0010 or 0110, `ovf` is 1 exactly when the operation overflows. For an add, that means both operands have the same sign and the result sign differs from them. For a subtract, that means the operand signs differ and the result sign differs from A.
- R5: When `arith_signed` is 0, `ovf` is 0 for every code. `ovf` is also 0 for every code other than 0010 and 0110.
- R6: Code 0111 sets result bit 0 to bit 31 of (A − B) modulo 2^32, with no overflow correction. Bits 31..1 are 0 and `ovf` is 0.
- R7: Code 1111 sets result bit 0 to 1 exactly when A < B as unsigned numbers, which is when the subtraction carry-out is 0. Bits 31..1 are 0 and `ovf` is 0.
- R8: `zero` is 1 exactly when all 32 result bits are 0.
- R9: When `use_imm` is 1, the second operand is the 16-bit `imm` widened to 32 bits. The upper 16 bits are copies of `imm[15]` when `imm_signed` is 1, and zeros when it is 0. When `use_imm` is 0, `opnd_b` is used and `imm` has no effect.
- R10: Every other code (0011, 0100, 0101, 1000–1011, 1110) gives a result of 0 with `ovf` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand from the register path |
| imm | input | 16 | Immediate field |
| use_imm | input | 1 | Select the widened immediate as the second operand |
| imm_signed | input | 1 | 1: sign-extend the immediate, 0: zero-extend it |
| arith_signed | input | 1 | 1: add and subtract may flag overflow |
| op_code | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | All result bits are zero |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The hardest case to reach is a signed comparison whose internal subtraction overflows. In that case the raw sign bit gives the opposite of the true order. Only operand pairs near the two extremes of the signed range produce it. The bench drives such pairs directly, for example the largest positive value against −1 and the most negative value against 1. It checks that the comparison bit follows the raw sign and that no overflow is flagged. The same extreme pairs are then issued as signed and unsigned subtracts to show that the flag depends only on `arith_signed`.

// File: rtl/intalu_pkg.sv
package intalu_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_NOR  = 4'b1100,
    OP_XOR  = 4'b1101,
    OP_SLTU = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2,
    LG_XOR = 2'd3
  } logic_fn_e;

  function automatic logic is_arith(input logic [OP_W-1:0] code);
    return (code == OP_ADD) || (code == OP_SUB);
  endfunction

  function automatic logic is_compare(input logic [OP_W-1:0] code);
    return (code == OP_SLT) || (code == OP_SLTU);
  endfunction

  function automatic logic needs_invert(input logic [OP_W-1:0] code);
    return (code == OP_SUB) || (code == OP_SLT) || (code == OP_SLTU);
  endfunction

  function automatic logic is_logic(input logic [OP_W-1:0] code);
    return (code == OP_AND) || (code == OP_OR) ||
           (code == OP_NOR) || (code == OP_XOR);
  endfunction

  function automatic logic_fn_e logic_sel(input logic [OP_W-1:0] code);
    case (code)
      OP_OR:   return LG_OR;
      OP_NOR:  return LG_NOR;
      OP_XOR:  return LG_XOR;
      default: return LG_AND;
    endcase
  endfunction

  // full-adder carry for one bit position
  function automatic logic carry_next(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a ^ b));
  endfunction
endpackage

// File: rtl/intalu_opsel.sv
module intalu_opsel #(
  parameter int W     = intalu_pkg::DATA_W,
  parameter int IMM_W = intalu_pkg::IMM_W
) (
  input  logic [W-1:0]     reg_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             imm_signed,
  output logic [W-1:0]     eff_b
);
  localparam int EXT_W = W - IMM_W;

  logic [EXT_W-1:0] fill;
  logic [W-1:0]     wide_imm;

  always_comb begin
    fill     = {EXT_W{imm_signed & imm[IMM_W-1]}};
    wide_imm = {fill, imm};
    eff_b    = use_imm ? wide_imm : reg_b;
  end
endmodule

// File: rtl/intalu_adder.sv
module intalu_adder #(
  parameter int W = intalu_pkg::DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  output logic [W-1:0] sum,
  output logic         carry_msb,
  output logic         carry_out
);
  import intalu_pkg::*;

  logic [W-1:0] b_cond;

  always_comb begin
    logic c;
    b_cond    = invert_b ? ~b : b;
    c         = invert_b;
    carry_msb = 1'b0;
    sum       = '0;
    for (int i = 0; i < W; i++) begin
      if (i == W - 1) carry_msb = c;
      sum[i] = a[i] ^ b_cond[i] ^ c;
      c      = carry_next(a[i], b_cond[i], c);
    end
    carry_out = c;
  end
endmodule

// File: rtl/intalu_logic.sv
module intalu_logic #(
  parameter int W = intalu_pkg::DATA_W
) (
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  input  intalu_pkg::logic_fn_e fn,
  output logic [W-1:0]          y
);
  import intalu_pkg::*;

  always_comb begin
    case (fn)
      LG_OR:   y = a | b;
      LG_NOR:  y = ~(a | b);
      LG_XOR:  y = a ^ b;
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/intalu.sv
module intalu #(
  parameter int W     = intalu_pkg::DATA_W,
  parameter int IMM_W = intalu_pkg::IMM_W,
  parameter int OP_W  = intalu_pkg::OP_W
) (
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             imm_signed,
  input  logic             arith_signed,
  input  logic [OP_W-1:0]  op_code,
  output logic [W-1:0]     result,
  output logic             zero,
  output logic             ovf
);
  import intalu_pkg::*;

  // named internal events for the checker
  logic [W-1:0] eff_b;
  logic [W-1:0] add_sum;
  logic         c_msb;
  logic         c_out;
  logic [W-1:0] logic_y;
  logic         raw_ovf;
  logic         slt_bit;
  logic         sltu_bit;

  intalu_opsel #(.W(W), .IMM_W(IMM_W)) u_opsel (
    .reg_b      (opnd_b),
    .imm        (imm),
    .use_imm    (use_imm),
    .imm_signed (imm_signed),
    .eff_b      (eff_b)
  );

  intalu_adder #(.W(W)) u_adder (
    .a         (opnd_a),
    .b         (eff_b),
    .invert_b  (needs_invert(op_code)),
    .sum       (add_sum),
    .carry_msb (c_msb),
    .carry_out (c_out)
  );

  intalu_logic #(.W(W)) u_logic (
    .a  (opnd_a),
    .b  (eff_b),
    .fn (logic_sel(op_code)),
    .y  (logic_y)
  );

  assign raw_ovf  = c_msb ^ c_out;
  assign slt_bit  = add_sum[W-1];
  assign sltu_bit = ~c_out;

  always_comb begin
    result = '0;
    if (is_logic(op_code))      result = logic_y;
    else if (is_arith(op_code)) result = add_sum;
    else if (op_code == OP_SLT) result = {{(W-1){1'b0}}, slt_bit};
    else if (op_code == OP_SLTU) result = {{(W-1){1'b0}}, sltu_bit};
  end

  assign ovf  = arith_signed & is_arith(op_code) & raw_ovf;
  assign zero = ~|result;
endmodule

// File: rtl/intalu_checker.sv
module intalu_checker #(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int OP_W  = 4
) (
  input logic [W-1:0]     opnd_a,
  input logic [IMM_W-1:0] imm,
  input logic             use_imm,
  input logic             imm_signed,
  input logic             arith_signed,
  input logic [OP_W-1:0]  op_code,
  input logic [W-1:0]     eff_b,
  input logic [W-1:0]     result,
  input logic             zero,
  input logic             ovf
);
  logic known_code;
  assign known_code = (op_code == 4'b0000) || (op_code == 4'b0001) ||
                      (op_code == 4'b0010) || (op_code == 4'b0110) ||
                      (op_code == 4'b0111) || (op_code == 4'b1100) ||
                      (op_code == 4'b1101) || (op_code == 4'b1111);

  always_comb begin
    assert_zero_flag_R8: assert (zero == (result == '0))
      else $error("zero flag mismatch");
    if (!arith_signed)
      assert_no_overflow_R5: assert (!ovf) else $error("ovf on unsigned op");
    if (op_code != 4'b0010 && op_code != 4'b0110)
      assert_ovf_arith_only_R5: assert (!ovf) else $error("ovf on non-arith op");
    if (op_code == 4'b0111 || op_code == 4'b1111)
      assert_compare_upper_clear_R6: assert (result[W-1:1] == '0)
        else $error("compare upper bits set");
    if (!known_code)
      assert_undef_code_R10: assert (result == '0 && !ovf)
        else $error("undefined code output");
    if (arith_signed && op_code == 4'b0010)
      assert_add_overflow_R4: assert (ovf == ((opnd_a[W-1] == eff_b[W-1]) &&
                                              (result[W-1] != opnd_a[W-1])))
        else $error("add overflow rule");
    if (use_imm)
      assert_imm_extend_R9: assert (eff_b[IMM_W-1:0] == imm &&
                                    eff_b[W-1:IMM_W] == {(W-IMM_W){imm_signed & imm[IMM_W-1]}})
        else $error("immediate widening");
  end
endmodule

bind intalu intalu_checker #(.W(W), .IMM_W(IMM_W), .OP_W(OP_W)) u_chk (
  .opnd_a       (opnd_a),
  .imm          (imm),
  .use_imm      (use_imm),
  .imm_signed   (imm_signed),
  .arith_signed (arith_signed),
  .op_code      (op_code),
  .eff_b        (eff_b),
  .result       (result),
  .zero         (zero),
  .ovf          (ovf)
);

// File: tb/intalu_test.sv
module intalu_test;
  logic        clk = 1'b0;
  logic [31:0] opnd_a, opnd_b;
  logic [15:0] imm;
  logic        use_imm, imm_signed, arith_signed;
  logic [3:0]  op_code;
  logic [31:0] result;
  logic        zero, ovf;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intalu uut (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .use_imm(use_imm),
    .imm_signed(imm_signed), .arith_signed(arith_signed), .op_code(op_code),
    .result(result), .zero(zero), .ovf(ovf)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive away from the clock edge and let the combinational path settle
  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sgn);
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b; arith_signed = sgn;
    #1;
  endtask

  // independent reference: wide arithmetic and sign rules
  task automatic expect_all(input string tag, input logic [31:0] b_used);
    logic [32:0] wide;
    logic [31:0] r;
    logic        o;
    r = '0; o = 1'b0;
    case (op_code)
      4'b0000: r = opnd_a & b_used;
      4'b0001: r = opnd_a | b_used;
      4'b1100: r = ~(opnd_a | b_used);
      4'b1101: r = opnd_a ^ b_used;
      4'b0010: begin
        wide = {1'b0, opnd_a} + {1'b0, b_used}; r = wide[31:0];
        o = arith_signed && (opnd_a[31] == b_used[31]) && (r[31] != opnd_a[31]);
      end
      4'b0110: begin
        r = opnd_a - b_used;
        o = arith_signed && (opnd_a[31] != b_used[31]) && (r[31] != opnd_a[31]);
      end
      4'b0111: begin wide[31:0] = opnd_a - b_used; r = {31'd0, wide[31]}; end
      4'b1111: r = {31'd0, (opnd_a < b_used)};
      default: r = '0;
    endcase
    check({tag, " result"}, result, r);
    check({tag, " ovf"}, {31'd0, ovf}, {31'd0, o});
    check({tag, " zero (R8)"}, {31'd0, zero}, {31'd0, (r == 0)});
  endtask

  task automatic t_idle;
    use_imm = 0; imm_signed = 0; imm = '0;
    apply(4'b0000, 32'h0, 32'h0, 1'b1);
    check("idle R8 zero", {31'd0, zero}, 32'd1);
    check("idle R1 result", result, 32'd0);
  endtask

  task automatic t_logic;
    apply(4'b0000, 32'hF0F0_1234, 32'hFF00_FF0F, 1'b1); expect_all("R1 and", opnd_b);
    apply(4'b0001, 32'hF0F0_1234, 32'h0F00_0001, 1'b1); expect_all("R1 or", opnd_b);
    apply(4'b1100, 32'h0000_0000, 32'h0000_0000, 1'b1); expect_all("R1 nor", opnd_b);
    check("R1 nor all ones", result, 32'hFFFF_FFFF);
    apply(4'b1101, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b1); expect_all("R1 xor", opnd_b);
  endtask

  task automatic t_add;
    apply(4'b0010, 32'd5, 32'd7, 1'b1); expect_all("R2 add", opnd_b);
    apply(4'b0010, 32'h7FFF_FFFF, 32'd1, 1'b1); expect_all("R4 add pos ovf", opnd_b);
    check("R4 add pos ovf set", {31'd0, ovf}, 32'd1);
    apply(4'b0010, 32'h8000_0000, 32'h8000_0000, 1'b1); expect_all("R4 add neg ovf", opnd_b);
    apply(4'b0010, 32'hFFFF_FFFF, 32'd1, 1'b1); expect_all("R2 add wrap", opnd_b);
    check("R2 wrap no ovf", {31'd0, ovf}, 32'd0);
  endtask

  task automatic t_sub;
    apply(4'b0110, 32'd9, 32'd9, 1'b1); expect_all("R3 sub equal", opnd_b);
    apply(4'b0110, 32'd3, 32'd10, 1'b1); expect_all("R3 sub neg", opnd_b);
    apply(4'b0110, 32'h8000_0000, 32'd1, 1'b1); expect_all("R4 sub ovf", opnd_b);
    check("R4 sub ovf set", {31'd0, ovf}, 32'd1);
  endtask

  task automatic t_unsigned;
    apply(4'b0010, 32'h7FFF_FFFF, 32'd1, 1'b0); expect_all("R5 addu", opnd_b);
    check("R5 addu ovf low", {31'd0, ovf}, 32'd0);
    apply(4'b0110, 32'h8000_0000, 32'd1, 1'b0); expect_all("R5 subu", opnd_b);
  endtask

  task automatic t_compare;
    apply(4'b0111, 32'hFFFF_FFFE, 32'd3, 1'b1); expect_all("R6 slt neg<pos", opnd_b);
    apply(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1); expect_all("R6 slt raw", opnd_b);
    check("R6 raw sign wins", result, 32'd1);
    apply(4'b0111, 32'h8000_0000, 32'd1, 1'b1); expect_all("R6 slt raw2", opnd_b);
    check("R6 raw sign 0", result, 32'd0);
    apply(4'b1111, 32'd3, 32'hFFFF_FFFE, 1'b1); expect_all("R7 sltu lt", opnd_b);
    check("R7 sltu one", result, 32'd1);
    apply(4'b1111, 32'd5, 32'd5, 1'b1); expect_all("R7 sltu eq", opnd_b);
  endtask

  task automatic t_imm;
    use_imm = 1; imm = 16'hFFFC; imm_signed = 1;
    apply(4'b0010, 32'd10, 32'hDEAD_BEEF, 1'b1); expect_all("R9 addi sext", 32'hFFFF_FFFC);
    check("R9 addi value", result, 32'd6);
    imm_signed = 0;
    apply(4'b0001, 32'h0, 32'hDEAD_BEEF, 1'b1); expect_all("R9 ori zext", 32'h0000_FFFC);
    imm = 16'h8000; imm_signed = 1;
    apply(4'b0111, 32'd0, 32'h0, 1'b1); expect_all("R9 slti sext", 32'hFFFF_8000);
    use_imm = 0; imm = 16'h1234;
    apply(4'b0010, 32'd1, 32'd2, 1'b1);
    check("R9 imm ignored", result, 32'd3);
  endtask

  task automatic t_undef;
    logic [3:0] codes [8] = '{4'b0011, 4'b0100, 4'b0101, 4'b1000,
                              4'b1001, 4'b1010, 4'b1011, 4'b1110};
    for (int i = 0; i < 8; i++) begin
      apply(codes[i], 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);
      check("R10 undef result", result, 32'd0);
      check("R10 undef ovf", {31'd0, ovf}, 32'd0);
    end
  endtask

  initial begin
    t_idle;
    t_logic;
    t_add;
    t_sub;
    t_unsigned;
    t_compare;
    t_imm;
    t_undef;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule